// File: doc/BRIEF.md
# Channel Loop Interrupt Collector

The block gathers loop-event notifications from a bank of sound-generation channels (64 by default) and presents them, together with a small set of other event sources, through one global status word. Each channel has a pending bit and an enable bit. A loop event on a channel sets that channel's pending bit only if the channel's enable bit is set. The pending bits and the enable bits are each held as two 32-bit words: one word for the lower half of the channels and one for the upper half.

The global status word shows a summary flag in bit 6. Bits 5:0 give the number of the highest pending channel. Other event sources occupy bits 9 upward; source 0, the interval timer terminal count, uses bit 9. Software writes the status word to acknowledge events. If the written word has bit 6 set, the channel named in bits 5:0 is cleared. Each source bit written as 1 is cleared, and every bit written as 0 is left alone. The interrupt output stays high while any enabled pending source remains. The register interface is a plain word-addressed write port with a combinational read.

Top module: `loop_irq_agg`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low.
- R2: A channel's pending bit is set at the clock edge where loop_evt_i for that channel is 1 and its enable bit is 1. A loop event on a channel whose enable bit is 0 leaves its pending bit unchanged.
- R3: Address 4 holds the enable bits for channels 0-31 (bit n is channel n). Address 5 holds the enable bits for channels 32-63 (bit n is channel 32+n). Both are read/write.
- R4: Address 2 holds the pending bits for channels 0-31 and address 3 those for channels 32-63, with the same bit layout as R3. Reading returns the current pending bits. A write loads the written value.
- R5: Address 0 is the global status word. Bit 6 reads 1 when any channel is pending. Bits 5:0 then hold the highest pending channel number. When no channel is pending, bits 6:0 read 0.
- R6: A write to address 0 with bit 6 set clears only the pending bit of the channel given in bits 5:0. A write to address 0 with bit 6 clear changes no channel pending bit.
- R7: A pulse on src_evt_i[k] sets global status bit 9+k; source 0 is the interval timer. A write to address 0 clears each such bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a set and a clear reach the same pending bit in the same cycle, the bit ends up set. This holds for a channel bit and for a source bit.
- R9: irq_o is high when either of two conditions holds. The first is that some source bit is pending and its global enable bit is set. The second is that some channel is pending and at least one channel enable bit is set.
- R10: Address 1 is the global enable word. Bits 9-12 are writable and readable and enable sources 0-3. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loop_evt_i | input | 64 | Per-channel loop event, one cycle per event |
| src_evt_i | input | 4 | Other event sources; bit 0 is interval timer terminal count |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register update takes effect at the clock edge that samples the event or the write. The read data, the status word and irq_o are combinational from those registers, so each result is due one edge after its stimulus. The bench applies stimulus just after a rising edge and removes it just after the next edge. It then settles the address and reads 1 ns later, so each check sees the state produced by exactly one edge. The channel sweep covers all 64 channels one at a time, then builds up the pending set in ascending order and clears it in descending order, so the highest-channel field is checked at every value.

// File: rtl/loop_irq_pkg.sv
package loop_irq_pkg;
  localparam int unsigned ADDR_GSTAT     = 0;
  localparam int unsigned ADDR_GENA      = 1;
  localparam int unsigned ADDR_PEND_BASE = 2;
endpackage

// File: rtl/loop_prio_find.sv
module loop_prio_find #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic              any_o,
  output logic [CW-1:0]     idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req_i[i]) idx_o = CW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/loop_chan_bank.sv
module loop_chan_bank #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned DW     = 32,
  localparam int unsigned NW = NUM_CH / DW,
  localparam int unsigned CW = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] loop_evt_i,
  input  logic [NW-1:0]     pend_wr_i,
  input  logic [NW-1:0]     ena_wr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              clr_en_i,
  input  logic [CW-1:0]     clr_idx_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] ena_o
);
  logic [NUM_CH-1:0] pend_q, ena_q, set_v, clr_v;

  assign set_v = loop_evt_i & ena_q;
  assign clr_v = clr_en_i ? (NUM_CH'(1) << clr_idx_i) : '0;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [DW-1:0] base_d;
    assign base_d = pend_wr_i[w] ? wdata_i : pend_q[w*DW +: DW];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[w*DW +: DW] <= '0;
        ena_q[w*DW +: DW]  <= '0;
      end else begin
        // set wins over both write-load and indexed clear
        pend_q[w*DW +: DW] <= (base_d & ~clr_v[w*DW +: DW]) | set_v[w*DW +: DW];
        if (ena_wr_i[w]) ena_q[w*DW +: DW] <= wdata_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;

  p_chan_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set_v)) == $past(set_v)));

  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|pend_wr_i) |=> ((pend_q & ~$past(pend_q) & ~$past(set_v)) == '0));

  p_clr_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(|pend_wr_i) && !loop_evt_i[clr_idx_i]) |=> !pend_q[$past(clr_idx_i)]);

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_v[clr_idx_i]) |=> pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/loop_src_pend.sv
module loop_src_pend #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic               w1c_en_i,
  input  logic               ena_wr_i,
  input  logic [NUM_SRC-1:0] wfield_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] ena_o
);
  logic [NUM_SRC-1:0] pend_q, ena_q, clr_v;

  assign clr_v = w1c_en_i ? wfield_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ena_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | src_evt_i;
      if (ena_wr_i) ena_q <= wfield_i;
    end
  end

  assign pend_o = pend_q;
  assign ena_o  = ena_q;

  p_src_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(src_evt_i)) == $past(src_evt_i)));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_en_i && (src_evt_i == '0)) |=> ((pend_q & $past(wfield_i)) == '0));

  p_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !w1c_en_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/loop_irq_agg.sv
module loop_irq_agg
  import loop_irq_pkg::*;
#(
  parameter int unsigned NUM_CH  = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SRC_LSB = 9,
  localparam int unsigned NW = NUM_CH / DW,
  localparam int unsigned CW = $clog2(NUM_CH),
  localparam int unsigned AW = $clog2(ADDR_PEND_BASE + 2 * NW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CH-1:0]  loop_evt_i,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wr_en_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  logic              gstat_wr, gena_wr;
  logic [NW-1:0]     pend_wr, ena_wr;
  logic [NUM_CH-1:0] ch_pend, ch_ena;
  logic [NUM_SRC-1:0] src_pend, src_ena;
  logic              ch_any;
  logic [CW-1:0]     ch_idx;
  logic [DW-1:0]     gstat;

  assign gstat_wr = wr_en_i && (addr_i == AW'(ADDR_GSTAT));
  assign gena_wr  = wr_en_i && (addr_i == AW'(ADDR_GENA));

  for (genvar w = 0; w < NW; w++) begin : g_dec
    assign pend_wr[w] = wr_en_i && (addr_i == AW'(ADDR_PEND_BASE + w));
    assign ena_wr[w]  = wr_en_i && (addr_i == AW'(ADDR_PEND_BASE + NW + w));
  end

  loop_chan_bank #(.NUM_CH(NUM_CH), .DW(DW)) u_bank (
    .clk_i, .rst_ni,
    .loop_evt_i,
    .pend_wr_i (pend_wr),
    .ena_wr_i  (ena_wr),
    .wdata_i,
    .clr_en_i  (gstat_wr && wdata_i[CW]),
    .clr_idx_i (wdata_i[CW-1:0]),
    .pend_o    (ch_pend),
    .ena_o     (ch_ena)
  );

  loop_src_pend #(.NUM_SRC(NUM_SRC)) u_src (
    .clk_i, .rst_ni,
    .src_evt_i,
    .w1c_en_i (gstat_wr),
    .ena_wr_i (gena_wr),
    .wfield_i (wdata_i[SRC_LSB +: NUM_SRC]),
    .pend_o   (src_pend),
    .ena_o    (src_ena)
  );

  loop_prio_find #(.NUM_CH(NUM_CH)) u_prio (
    .req_i (ch_pend),
    .any_o (ch_any),
    .idx_o (ch_idx)
  );

  always_comb begin
    gstat = '0;
    gstat[SRC_LSB +: NUM_SRC] = src_pend;
    gstat[CW] = ch_any;
    gstat[CW-1:0] = ch_any ? ch_idx : '0;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(ADDR_GSTAT)) rdata_o = gstat;
    if (addr_i == AW'(ADDR_GENA))  rdata_o[SRC_LSB +: NUM_SRC] = src_ena;
    for (int w = 0; w < NW; w++) begin
      if (addr_i == AW'(ADDR_PEND_BASE + w))      rdata_o = ch_pend[w*DW +: DW];
      if (addr_i == AW'(ADDR_PEND_BASE + NW + w)) rdata_o = ch_ena[w*DW +: DW];
    end
  end

  assign irq_o = (|(src_pend & src_ena)) | (ch_any & (|ch_ena));

  p_idx_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_any |-> (ch_pend[ch_idx] && ((ch_pend >> ch_idx) == NUM_CH'(1))));

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((|(src_pend & src_ena)) || ((ch_pend != '0) && (ch_ena != '0))));
endmodule

// File: tb/loop_irq_agg_test.sv
`timescale 1ns/1ps
module loop_irq_agg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] loop_evt_i = '0;
  logic [3:0]  src_evt_i = '0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  loop_irq_agg uut (.*);

  always #2.5 clk_i = ~clk_i;

  initial begin
    #1ms;
    bad++;
    $display("FAIL watchdog: act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    edge1();
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse_ch(input logic [63:0] v);
    loop_evt_i = v; edge1(); loop_evt_i = '0;
  endtask

  task automatic set_ena(input logic [63:0] v);
    wr(3'd4, v[31:0]); wr(3'd5, v[63:32]);
  endtask

  logic [31:0] d;

  initial begin
    #12 rst_ni = 1'b1;
    edge1();

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R3 enable words readback
    set_ena({32'h1234_5678, 32'hA5A5_0F0F});
    rd(3'd4, d); chk("R3 ena lo", d, 32'hA5A5_0F0F);
    rd(3'd5, d); chk("R3 ena hi", d, 32'h1234_5678);

    // R2 disabled channels ignore events
    set_ena(64'h0);
    pulse_ch('1);
    rd(3'd2, d); chk("R2 disabled lo", d, 32'h0);
    rd(3'd3, d); chk("R2 disabled hi", d, 32'h0);
    chk("R2 disabled irq", {31'b0, irq_o}, 32'h0);

    // exhaustive single-channel sweep
    for (int ch = 0; ch < 64; ch++) begin
      logic [63:0] one;
      one = 64'd1 << ch;
      set_ena(one);
      pulse_ch('1);
      rd(3'd0, d); chk("R5 single gstat", d, 32'h40 | ch);
      rd(3'd2, d); chk("R2 single lo", d, one[31:0]);
      rd(3'd3, d); chk("R4 single hi", d, one[63:32]);
      chk("R9 single irq", {31'b0, irq_o}, 32'h1);
      wr(3'd0, 32'h40 | ch);
      rd(3'd0, d); chk("R6 single clr", d, 32'h0);
      chk("R9 cleared irq", {31'b0, irq_o}, 32'h0);
    end

    // ascending build, highest follows
    set_ena('1);
    for (int ch = 0; ch < 64; ch++) begin
      pulse_ch(64'd1 << ch);
      rd(3'd0, d); chk("R5 ascend", d, 32'h40 | ch);
    end
    wr(3'd0, 32'h3F);
    rd(3'd2, d); chk("R6 no bit6 lo", d, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R6 no bit6 hi", d, 32'hFFFF_FFFF);
    wr(3'd0, 32'h40 | 5);
    rd(3'd2, d); chk("R6 only one lo", d, 32'hFFFF_FFDF);
    rd(3'd3, d); chk("R6 only one hi", d, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R5 still top", d, 32'h7F);
    for (int ch = 63; ch >= 0; ch--) begin
      wr(3'd0, 32'h40 | ch);
      rd(3'd0, d);
      if (ch == 0) chk("R5 descend empty", d, 32'h0);
      else if (ch == 6) chk("R5 descend skip", d, 32'h40 | 4);
      else if (ch > 5) chk("R5 descend", d, 32'h40 | (ch - 1));
      else if (ch > 1) chk("R5 descend low", d, 32'h40 | (ch - 1));
      else chk("R5 descend one", d, 32'h40);
    end

    // R4 pending word load
    wr(3'd2, 32'h8000_0001);
    rd(3'd0, d); chk("R4 load lo gstat", d, 32'h40 | 31);
    wr(3'd3, 32'h0000_0001);
    rd(3'd0, d); chk("R4 load hi gstat", d, 32'h40 | 32);
    rd(3'd3, d); chk("R4 hi readback", d, 32'h1);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    rd(3'd0, d); chk("R4 cleared", d, 32'h0);

    // R8 channel set wins over clear
    pulse_ch(64'd1 << 40);
    addr_i = 3'd0; wdata_i = 32'h40 | 40; wr_en_i = 1'b1; loop_evt_i = 64'd1 << 40;
    edge1();
    wr_en_i = 1'b0; wdata_i = '0; loop_evt_i = '0;
    rd(3'd0, d); chk("R8 chan set wins", d, 32'h40 | 40);

    // R9 channel summary gated by any channel enable
    set_ena(64'h0);
    chk("R9 no chan ena irq", {31'b0, irq_o}, 32'h0);
    set_ena(64'h8000_0000_0000_0000);
    chk("R9 any chan ena irq", {31'b0, irq_o}, 32'h1);
    wr(3'd0, 32'h40 | 40);
    set_ena(64'h0);

    // R7/R10 sources
    src_evt_i = 4'b0001; edge1(); src_evt_i = '0;
    rd(3'd0, d); chk("R7 timer bit9", d, 32'h200);
    chk("R9 src disabled irq", {31'b0, irq_o}, 32'h0);
    wr(3'd1, 32'h200);
    rd(3'd1, d); chk("R10 gena read", d, 32'h200);
    chk("R9 src enabled irq", {31'b0, irq_o}, 32'h1);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R10 gena mask", d, 32'h1E00);
    src_evt_i = 4'b1110; edge1(); src_evt_i = '0;
    rd(3'd0, d); chk("R7 all src", d, 32'h1E00);
    wr(3'd0, 32'h400);
    rd(3'd0, d); chk("R7 w1c one", d, 32'h1A00);
    wr(3'd0, 32'h0);
    rd(3'd0, d); chk("R7 zero keeps", d, 32'h1A00);
    addr_i = 3'd0; wdata_i = 32'h200; wr_en_i = 1'b1; src_evt_i = 4'b0001;
    edge1();
    wr_en_i = 1'b0; wdata_i = '0; src_evt_i = '0;
    rd(3'd0, d); chk("R8 src set wins", d, 32'h1A00);
    wr(3'd0, 32'h1E00);
    rd(3'd0, d); chk("R7 all cleared", d, 32'h0);
    chk("R9 final irq", {31'b0, irq_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule